// File: doc/BRIEF.md
# Multi-User Inter-Processor Mailbox

This block is a memory-mapped message exchange for several processors on one chip. It holds a parameterised number of small hardware queues. Each queue carries 32-bit words from a sender to a receiver. A processor posts a word by writing a queue's message port. Another processor takes the oldest word by reading the same port. Per-queue occupancy and full registers let software poll the queues without consuming anything.

Every user (one per processor) owns an interrupt status register and an enable register. Each of these has two event bits per queue. Bit 2m is "queue m holds a message" and bit 2m+1 is "queue m just left the full condition". A user's level interrupt is raised while any enabled status bit is set. The address layout is chosen at build time. In the legacy layout the enable register is written as a whole. In the enhanced layout the enable has separate set and clear registers.

Each queue is controlled by a three-state machine:
- EMPTY goes to PARTIAL on an accepted push.
- PARTIAL goes to FULL on a push that brings the occupancy to the depth.
- PARTIAL goes to EMPTY on a pop of the last entry.
- FULL goes to PARTIAL on a pop.
- Every other combination holds the state. A push while FULL is discarded. A pop while EMPTY is ignored.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty, and every occupancy, status and enable register reads 0. All interrupt outputs are low.
- R2: Offset 0x000 is read-only. It returns the major revision in bits 7:4 and the minor revision in bits 3:0 (default 0x21). Writes to it have no effect.
- R3: A write to offset 0x040+4*m pushes the write data into queue m. A read of that offset returns the oldest word in the same cycle and removes it, so words leave in the order they were written.
- R4: Offset 0x080+4*m reads 1 while queue m holds FIFO_DEPTH words and 0 otherwise. Offset 0x0C0+4*m reads the number of words queued.
- R5: A push to a full queue is dropped and leaves its contents unchanged. A read of an empty queue's port returns 0 and changes nothing.
- R6: Status bit 2*m of every user is set at each clock edge at which queue m is non-empty. It therefore reads 1 from the second cycle after a push into an empty queue.
- R7: Status bit 2*m+1 of every user is set at the edge where a pop takes queue m out of the full condition.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it. When a clear and a new event hit the same bit at the same edge, the event wins.
- R9: In the legacy layout, user u has its status register at 0x100+8*u and its enable register at 0x104+8*u. A write to the enable register replaces all of its bits.
- R10: In the enhanced layout, user u has status at 0x104+0x10*u, enable-set at 0x108+0x10*u and enable-clear at 0x10C+0x10*u. Writing 1 sets or clears the matching enable bit. Both the set and clear offsets read back the enable value.
- R11: Interrupt output u is high exactly while the AND of user u's status and enable registers is nonzero.
- R12: Offsets that are not mapped in the selected layout read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, acts at the next rising edge |
| bus_rd | input | 1 | Read strobe; data returned in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | NUM_USERS | Level interrupt per user |

## Verification
Read data is due in the cycle that carries the read strobe. A push or pop shows in the occupancy registers one cycle later. Status event bits appear one edge after the queue condition that causes them, so a new message is visible on a status read two cycles after its write. The interrupt outputs follow the registered status and enable with no added delay. The bench drives each access at the falling edge and samples read data and interrupts one nanosecond later. It then advances its reference model at the rising edge, so every expected value comes from the model state that the registers hold in that cycle.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        FIFO_EMPTY   = 2'd0,
        FIFO_PARTIAL = 2'd1,
        FIFO_FULL    = 2'd2
    } fifo_state_e;

    localparam logic [ADDR_W-1:0] REV_OFF = '0;

    function automatic logic [ADDR_W-1:0] msg_off(input int m);
        return ADDR_W'(32'h040 + 4 * m);
    endfunction

    function automatic logic [ADDR_W-1:0] full_off(input int m);
        return ADDR_W'(32'h080 + 4 * m);
    endfunction

    function automatic logic [ADDR_W-1:0] level_off(input int m);
        return ADDR_W'(32'h0C0 + 4 * m);
    endfunction

    function automatic logic [ADDR_W-1:0] leg_stat_off(input int u);
        return ADDR_W'(32'h100 + 8 * u);
    endfunction

    function automatic logic [ADDR_W-1:0] leg_en_off(input int u);
        return ADDR_W'(32'h104 + 8 * u);
    endfunction

    function automatic logic [ADDR_W-1:0] enh_stat_off(input int u);
        return ADDR_W'(32'h104 + 16 * u);
    endfunction

    function automatic logic [ADDR_W-1:0] enh_set_off(input int u);
        return ADDR_W'(32'h108 + 16 * u);
    endfunction

    function automatic logic [ADDR_W-1:0] enh_clr_off(input int u);
        return ADDR_W'(32'h10C + 16 * u);
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
`timescale 1ns/1ps
module mbx_fifo
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         nonempty,
    output logic                         pop_from_full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = $clog2(DEPTH);

    fifo_state_e       state_q, state_d;
    logic [CW-1:0]     count_q;
    logic [PW-1:0]     rd_ptr_q, wr_ptr_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              do_push, do_pop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (state_q != FIFO_FULL);
    assign do_pop  = pop  && (state_q != FIFO_EMPTY);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FIFO_EMPTY: begin
                if (do_push) state_d = (DEPTH == 1) ? FIFO_FULL : FIFO_PARTIAL;
            end
            FIFO_PARTIAL: begin
                if (do_push && !do_pop && count_q == CW'(DEPTH - 1))
                    state_d = FIFO_FULL;
                else if (do_pop && !do_push && count_q == CW'(1))
                    state_d = FIFO_EMPTY;
            end
            FIFO_FULL: begin
                if (do_pop) state_d = (DEPTH == 1) ? FIFO_EMPTY : FIFO_PARTIAL;
            end
            default: state_d = FIFO_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FIFO_EMPTY;
        else        state_q <= state_d;
    end

    // datapath: occupancy and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
        end else begin
            count_q <= count_q + CW'(do_push) - CW'(do_pop);
            if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr_q] <= wdata;
    end

    // outputs
    always_comb begin
        full          = (state_q == FIFO_FULL);
        nonempty      = (state_q != FIFO_EMPTY);
        pop_from_full = do_pop && (state_q == FIFO_FULL);
        count         = count_q;
        head          = mem[rd_ptr_q];
    end

    // R4: state machine and occupancy counter agree
    a_r4_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIFO_FULL) |-> (count_q == CW'(DEPTH)));
    a_r4_empty_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIFO_EMPTY) |-> (count_q == '0));
    // R5: a push into a full queue is dropped
    a_r5_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIFO_FULL && push && !pop) |=> $stable(count_q));
    // R5: a pop of an empty queue changes nothing
    a_r5_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIFO_EMPTY && pop && !push) |=> (state_q == FIFO_EMPTY));
    // R7: a pop always leaves the full condition
    a_r7_leave_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIFO_FULL && pop) |=> (state_q != FIFO_FULL));

endmodule

// File: rtl/mbx_user_irq.sv
`timescale 1ns/1ps
module mbx_user_irq #(
    parameter int SW       = 8,
    parameter bit ENHANCED = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stat_wr,
    input  logic          en_wr,
    input  logic          en_set,
    input  logic          en_clr,
    input  logic [SW-1:0] wdata,
    input  logic [SW-1:0] evt,
    output logic [SW-1:0] stat,
    output logic [SW-1:0] en,
    output logic          irq
);
    logic [SW-1:0] stat_q, en_q;
    logic [SW-1:0] clr_mask;
    logic          unused_strobes;

    assign unused_strobes = en_wr ^ en_set ^ en_clr;
    assign clr_mask = stat_wr ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | evt;
    end

    if (ENHANCED) begin : g_enh
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      en_q <= '0;
            else if (en_set) en_q <= en_q | wdata;
            else if (en_clr) en_q <= en_q & ~wdata;
        end
        // R10: set and clear registers act bit by bit
        a_r10_en_set: assert property (@(posedge clk) disable iff (!rst_n)
            en_set |=> ((en_q & $past(wdata)) == $past(wdata)));
        a_r10_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
            (en_clr && !en_set) |=> ((en_q & $past(wdata)) == '0));
    end else begin : g_leg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     en_q <= '0;
            else if (en_wr) en_q <= wdata;
        end
        // R9: legacy enable write replaces the register
        a_r9_en_write: assert property (@(posedge clk) disable iff (!rst_n)
            en_wr |=> (en_q == $past(wdata)));
    end

    assign stat = stat_q;
    assign en   = en_q;
    assign irq  = |(stat_q & en_q);

    // R8: written ones are cleared unless an event hits the same bit
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((stat_q & $past(wdata) & ~$past(evt)) == '0));
    // R6 / R8: events always land, even against a clear
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/ipc_mailbox.sv
`timescale 1ns/1ps
module ipc_mailbox
    import mbx_pkg::*;
#(
    parameter int          NUM_FIFOS  = 4,
    parameter int          NUM_USERS  = 2,
    parameter int          FIFO_DEPTH = 4,
    parameter bit          ENHANCED   = 1'b0,
    parameter logic [3:0]  REV_MAJOR  = 4'd2,
    parameter logic [3:0]  REV_MINOR  = 4'd1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_USERS-1:0] irq
);
    localparam int SW = 2 * NUM_FIFOS;
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [NUM_FIFOS-1:0] push, pop, full, nonempty, pop_full;
    logic [31:0]          head  [NUM_FIFOS];
    logic [CW-1:0]        count [NUM_FIFOS];
    logic [SW-1:0]        evt;
    logic [SW-1:0]        stat  [NUM_USERS];
    logic [SW-1:0]        en    [NUM_USERS];
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:SW];

    for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_fifo
        assign push[m] = bus_wr && (bus_addr == msg_off(m));
        assign pop[m]  = bus_rd && (bus_addr == msg_off(m));

        mbx_fifo #(.DATA_W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk           (clk),
            .rst_n         (rst_n),
            .push          (push[m]),
            .pop           (pop[m]),
            .wdata         (bus_wdata),
            .head          (head[m]),
            .count         (count[m]),
            .full          (full[m]),
            .nonempty      (nonempty[m]),
            .pop_from_full (pop_full[m])
        );

        assign evt[2*m]   = nonempty[m];
        assign evt[2*m+1] = pop_full[m];
    end

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
        logic stat_wr, en_wr, en_set, en_clr;

        if (ENHANCED) begin : g_enh_dec
            assign stat_wr = bus_wr && (bus_addr == enh_stat_off(u));
            assign en_wr   = 1'b0;
            assign en_set  = bus_wr && (bus_addr == enh_set_off(u));
            assign en_clr  = bus_wr && (bus_addr == enh_clr_off(u));
        end else begin : g_leg_dec
            assign stat_wr = bus_wr && (bus_addr == leg_stat_off(u));
            assign en_wr   = bus_wr && (bus_addr == leg_en_off(u));
            assign en_set  = 1'b0;
            assign en_clr  = 1'b0;
        end

        mbx_user_irq #(.SW(SW), .ENHANCED(ENHANCED)) u_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .stat_wr (stat_wr),
            .en_wr   (en_wr),
            .en_set  (en_set),
            .en_clr  (en_clr),
            .wdata   (bus_wdata[SW-1:0]),
            .evt     (evt),
            .stat    (stat[u]),
            .en      (en[u]),
            .irq     (irq[u])
        );
    end

    // read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == REV_OFF)
            bus_rdata = {24'b0, REV_MAJOR, REV_MINOR};
        for (int m = 0; m < NUM_FIFOS; m++) begin
            if (bus_addr == msg_off(m) && nonempty[m]) bus_rdata = head[m];
            if (bus_addr == full_off(m))               bus_rdata = {31'b0, full[m]};
            if (bus_addr == level_off(m))              bus_rdata = 32'(count[m]);
        end
        for (int u = 0; u < NUM_USERS; u++) begin
            if (ENHANCED) begin
                if (bus_addr == enh_stat_off(u)) bus_rdata = 32'(stat[u]);
                if (bus_addr == enh_set_off(u) || bus_addr == enh_clr_off(u))
                    bus_rdata = 32'(en[u]);
            end else begin
                if (bus_addr == leg_stat_off(u)) bus_rdata = 32'(stat[u]);
                if (bus_addr == leg_en_off(u))   bus_rdata = 32'(en[u]);
            end
        end
    end

    // R11: an interrupt needs an enabled and pending status bit at the port level
    a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> (evt != '0 || $past(evt) != '0 || $past(irq) != '0 || $past(bus_wr)));
    // R1: no interrupt in the first cycle after reset release
    a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0));

endmodule

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
    localparam int NF  = 4;
    localparam int NU  = 2;
    localparam int DEP = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic        wr_l, rd_l, wr_e, rd_e;
    logic [31:0] rdata_l, rdata_e;
    logic [NU-1:0] irq_l, irq_e;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    int          mcnt [2][NF];
    logic [31:0] mdat [2][NF][DEP];
    logic [7:0]  mstat[2][NU];
    logic [7:0]  men  [2][NU];

    always #5 clk = ~clk;

    ipc_mailbox #(.NUM_FIFOS(NF), .NUM_USERS(NU), .FIFO_DEPTH(DEP), .ENHANCED(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_l), .bus_rd(rd_l),
        .bus_wdata(wdata), .bus_rdata(rdata_l), .irq(irq_l));

    ipc_mailbox #(.NUM_FIFOS(NF), .NUM_USERS(NU), .FIFO_DEPTH(DEP), .ENHANCED(1'b1)) dut_enh (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_e), .bus_rd(rd_e),
        .bus_wdata(wdata), .bus_rdata(rdata_e), .irq(irq_e));

    function automatic logic [11:0] a_msg(int m);  return 12'(32'h040 + 4*m); endfunction
    function automatic logic [11:0] a_full(int m); return 12'(32'h080 + 4*m); endfunction
    function automatic logic [11:0] a_lvl(int m);  return 12'(32'h0C0 + 4*m); endfunction
    function automatic logic [11:0] a_stat(int s, int u);
        return (s == 0) ? 12'(32'h100 + 8*u) : 12'(32'h104 + 16*u);
    endfunction
    function automatic logic [11:0] a_en(int s, int u);
        return (s == 0) ? 12'(32'h104 + 8*u) : 12'(32'h108 + 16*u);
    endfunction
    function automatic logic [11:0] a_clr(int u); return 12'(32'h10C + 16*u); endfunction

    function automatic logic [31:0] exp_rd(int s, logic [11:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 12'h000) r = 32'h21;
        for (int m = 0; m < NF; m++) begin
            if (a == a_msg(m) && mcnt[s][m] > 0) r = mdat[s][m][0];
            if (a == a_full(m)) r = (mcnt[s][m] == DEP) ? 32'd1 : 32'd0;
            if (a == a_lvl(m))  r = 32'(mcnt[s][m]);
        end
        for (int u = 0; u < NU; u++) begin
            if (a == a_stat(s, u)) r = {24'b0, mstat[s][u]};
            if (a == a_en(s, u))   r = {24'b0, men[s][u]};
            if (s == 1 && a == a_clr(u)) r = {24'b0, men[s][u]};
        end
        return r;
    endfunction

    function automatic logic [NU-1:0] exp_irq(int s);
        logic [NU-1:0] v;
        for (int u = 0; u < NU; u++) v[u] = |(mstat[s][u] & men[s][u]);
        return v;
    endfunction

    task automatic step(int s, bit wr, bit rd, logic [11:0] a, logic [31:0] d);
        logic [7:0] evt;
        logic [7:0] clr;
        evt = '0;
        for (int m = 0; m < NF; m++) begin
            evt[2*m]   = (mcnt[s][m] > 0);
            evt[2*m+1] = rd && (a == a_msg(m)) && (mcnt[s][m] == DEP);
        end
        for (int u = 0; u < NU; u++) begin
            clr = (wr && a == a_stat(s, u)) ? d[7:0] : 8'h00;
            mstat[s][u] = (mstat[s][u] & ~clr) | evt;
            if (s == 0 && wr && a == a_en(0, u)) men[s][u] = d[7:0];
            if (s == 1 && wr && a == a_en(1, u)) men[s][u] = men[s][u] | d[7:0];
            if (s == 1 && wr && a == a_clr(u))   men[s][u] = men[s][u] & ~d[7:0];
        end
        for (int m = 0; m < NF; m++) begin
            if (wr && a == a_msg(m) && mcnt[s][m] < DEP) begin
                mdat[s][m][mcnt[s][m]] = d;
                mcnt[s][m]++;
            end
            if (rd && a == a_msg(m) && mcnt[s][m] > 0) begin
                for (int k = 0; k < DEP-1; k++) mdat[s][m][k] = mdat[s][m][k+1];
                mcnt[s][m]--;
            end
        end
    endtask

    task automatic check(logic [31:0] got, logic [31:0] exp, string tag);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one bus cycle on layout s (0 legacy, 1 enhanced)
    task automatic op(int s, bit wr, bit rd, logic [11:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_l  = (s == 0) && wr;
        rd_l  = (s == 0) && rd;
        wr_e  = (s == 1) && wr;
        rd_e  = (s == 1) && rd;
        #1;
        if (rd) check((s == 0) ? rdata_l : rdata_e, exp_rd(s, a), tag);
        check(32'(irq_l), 32'(exp_irq(0)), "R11 legacy irq");
        check(32'(irq_e), 32'(exp_irq(1)), "R11 enhanced irq");
        @(posedge clk);
        step(0, (s == 0) && wr, (s == 0) && rd, a, d);
        step(1, (s == 1) && wr, (s == 1) && rd, a, d);
    endtask

    task automatic idle(); op(0, 1'b0, 1'b0, 12'hFFC, 32'h0, "idle"); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < NF; m++) mcnt[s][m] = 0;
            for (int u = 0; u < NU; u++) begin mstat[s][u] = '0; men[s][u] = '0; end
        end
        rst_n = 1'b0;
        addr = '0; wdata = '0; wr_l = 0; rd_l = 0; wr_e = 0; rd_e = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of both layouts
        #1;
        check(32'(irq_l), 32'h0, "R1 legacy irq after reset");
        check(32'(irq_e), 32'h0, "R1 enhanced irq after reset");
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < NF; m++) op(s, 0, 1, a_lvl(m), 0, "R1 level");
            for (int u = 0; u < NU; u++) begin
                op(s, 0, 1, a_stat(s, u), 0, "R1 status");
                op(s, 0, 1, a_en(s, u), 0, "R1 enable");
            end
        end

        // R2: revision register, read only
        op(0, 0, 1, 12'h000, 0, "R2 revision");
        op(0, 1, 0, 12'h000, 32'hFFFF_FFFF, "R2 write");
        op(0, 0, 1, 12'h000, 0, "R2 revision after write");

        // R3/R4/R5: fill queue 1, overflow, drain in order
        op(0, 1, 0, a_msg(1), 32'hA000_0001, "R3 push");
        op(0, 1, 0, a_msg(1), 32'hB000_0002, "R3 push");
        op(0, 1, 0, a_msg(1), 32'hC000_0003, "R3 push");
        op(0, 1, 0, a_msg(1), 32'hD000_0004, "R3 push");
        op(0, 0, 1, a_lvl(1), 0, "R4 level at full");
        op(0, 0, 1, a_full(1), 0, "R4 full flag set");
        op(0, 1, 0, a_msg(1), 32'hEEEE_EEEE, "R5 push to full");
        op(0, 0, 1, a_lvl(1), 0, "R5 level after dropped push");
        op(0, 0, 1, a_msg(1), 0, "R3 pop oldest");
        op(0, 0, 1, a_full(1), 0, "R4 full flag clear");
        op(0, 0, 1, a_stat(0, 0), 0, "R7 not-full event");
        op(0, 0, 1, a_msg(1), 0, "R3 pop second");
        op(0, 0, 1, a_msg(1), 0, "R3 pop third");
        op(0, 0, 1, a_msg(1), 0, "R3 pop fourth");
        op(0, 0, 1, a_msg(1), 0, "R5 pop empty returns 0");
        op(0, 0, 1, a_lvl(1), 0, "R5 level stays 0");

        // R8/R6: clearing and re-setting status
        op(0, 1, 0, a_stat(0, 0), 32'hFF, "R8 clear all");
        op(0, 0, 1, a_stat(0, 0), 0, "R8 status cleared");
        op(0, 1, 0, a_msg(0), 32'h1234_5678, "R6 push");
        op(0, 0, 1, a_stat(0, 0), 0, "R6 not yet set");
        op(0, 0, 1, a_stat(0, 0), 0, "R6 new-message set");
        op(0, 1, 0, a_stat(0, 0), 32'h00, "R8 write zero");
        op(0, 0, 1, a_stat(0, 0), 0, "R8 zero has no effect");
        op(0, 1, 0, a_stat(0, 0), 32'h01, "R8 clear vs event");
        op(0, 0, 1, a_stat(0, 0), 0, "R8 event wins");

        // R9/R11: legacy enable and interrupt
        op(0, 1, 0, a_en(0, 1), 32'h01, "R9 enable write");
        op(0, 0, 1, a_en(0, 1), 0, "R9 enable read");
        op(0, 0, 1, a_stat(0, 1), 0, "R11 user1 pending");
        op(0, 1, 0, a_en(0, 1), 32'h00, "R9 enable overwrite");
        op(0, 0, 1, a_msg(0), 0, "R3 pop single");
        idle();
        op(0, 1, 0, a_stat(0, 1), 32'hFF, "R8 clear user1");

        // R10/R12: enhanced layout
        op(1, 1, 0, a_en(1, 0), 32'h0F, "R10 set");
        op(1, 1, 0, a_en(1, 0), 32'h30, "R10 set more");
        op(1, 0, 1, a_en(1, 0), 0, "R10 set read");
        op(1, 1, 0, a_clr(0), 32'h05, "R10 clear");
        op(1, 0, 1, a_clr(0), 0, "R10 clear read");
        op(1, 1, 0, a_msg(2), 32'h5555_AAAA, "R10 push for irq");
        idle();
        op(1, 0, 1, a_stat(1, 0), 0, "R10 enhanced status");
        op(1, 0, 1, 12'h100, 0, "R12 enhanced unmapped");
        op(0, 1, 0, 12'h010, 32'hDEAD_BEEF, "R12 write unmapped");
        op(0, 0, 1, 12'h010, 0, "R12 read unmapped");
        op(0, 0, 1, 12'h200, 0, "R12 read beyond map");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int s, k, m, u;
            logic [31:0] d;
            s = int'($urandom % 2);
            k = int'($urandom % 8);
            m = int'($urandom % NF);
            u = int'($urandom % NU);
            d = $urandom;
            case (k)
                0, 1: op(s, 1, 0, a_msg(m), d, "R3 random push");
                2, 3: op(s, 0, 1, a_msg(m), 0, "R3 random pop");
                4:    op(s, 0, 1, ($urandom % 2) ? a_full(m) : a_lvl(m), 0, "R4 random level");
                5:    op(s, 1, 0, a_stat(s, u), d, "R8 random clear");
                6:    op(s, 1, 0, (s == 1 && ($urandom % 2)) ? a_clr(u) : a_en(s, u), d,
                         "R10 random enable");
                default: op(s, 0, 1, ($urandom % 2) ? a_stat(s, u) : a_en(s, u), 0,
                            "R6 random status");
            endcase
        end
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule